// File: doc/BRIEF.md
# Window Pixel Transfer Sequencer

This block takes 16-bit words arriving on a pixel data port and places them into a rectangular window of a frame buffer. A window is described by inclusive start and end corners, a format code that fixes the bytes per pixel, and a source selector. The block checks the window, works out how many words the transfer needs, counts accepted words down, and emits one frame-buffer write per word. When the last word is written it pulses a completion flag.

A transfer can be armed in two ways. An explicit setup strobe arms it. A word that arrives while nothing is pending also arms it, and that word becomes the first word of the transfer. A window that fails its checks is refused. If the refused setup was triggered by a word, that word is dropped.

Every finished window is merged into a dirty bounding box that the display refresh logic reads. A refresh strobe returns a non-empty box to its empty form. The block also latches a rotation code at setup time for the drawing logic downstream.

Top module: `pix_window_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_we` are 0. The dirty box is empty: `dirty_x0` and `dirty_y0` are all ones, and `dirty_x1` and `dirty_y1` are 0.
- R2: Format codes give bytes per pixel as follows: 1 gives 2, 2 and 3 give 3, 6 and 7 give 4. The word count is bytes_per_pixel × (x_end − x_start + 1) × (y_end − y_start + 1) / 2, rounded down.
- R3: A setup is refused if `src_sel` > 3, if the format code is not one of those listed in R2, or if either end coordinate is below its start. A refused setup leaves the pending transfer unchanged. A word that triggers a refused setup produces no write.
- R4: Asserting `setup_stb` with a valid window loads the word count. `busy` is 1 exactly while the remaining count is non-zero.
- R5: A word that arrives while the remaining count is 0 runs the setup. If the window is valid, that word is written as the first word of the new transfer.
- R6: With format code 1, word i goes to address (y_start + i / width) × `panel_w` + x_start + i mod width, which is raster order within the window. With any other valid format, word i goes to y_start × `panel_w` + x_start + i.
- R7: `done` is a single-cycle pulse that appears together with the write of the last word, and `busy` falls at the same moment.
- R8: On completion, the dirty box grows to cover the window. Each minimum is lowered to the window start if that is smaller. Each maximum is raised to start + size if that is larger.
- R9: A `refresh_stb` while `dirty_x1` > `dirty_x0` sets the box to (`panel_w`, `panel_h`, 0, 0). When `dirty_x1` ≤ `dirty_x0` a refresh leaves the box unchanged.
- R10: `rot_mode` takes the value of `effect_rot` at each accepted setup and holds it until the next one.
- R11: A word presented in the same cycle as `setup_stb` is dropped.
- R12: `mem_we`, `mem_addr` and `mem_data` are registered. They appear one clock after the accepted word, and `mem_data` equals that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_x0 | input | COORD_W | Window start column |
| win_y0 | input | COORD_W | Window start row |
| win_x1 | input | COORD_W | Window end column (inclusive) |
| win_y1 | input | COORD_W | Window end row (inclusive) |
| fmt_code | input | 4 | Input pixel format code |
| src_sel | input | 3 | Source selector |
| effect_rot | input | 2 | Rotation code, sampled at setup |
| setup_stb | input | 1 | Explicit setup request |
| pix_valid | input | 1 | Pixel port word strobe |
| pix_data | input | 16 | Pixel port word |
| panel_w | input | COORD_W | Panel width, which is also the line pitch |
| panel_h | input | COORD_W | Panel height |
| refresh_stb | input | 1 | Refresh has consumed the dirty box |
| mem_we | output | 1 | Frame-buffer write enable |
| mem_addr | output | ADDR_W | Frame-buffer word address |
| mem_data | output | 16 | Frame-buffer write data |
| done | output | 1 | Transfer completion pulse |
| busy | output | 1 | Remaining count is non-zero |
| rot_mode | output | 2 | Rotation code latched at setup |
| dirty_x0 | output | COORD_W+1 | Dirty box minimum column |
| dirty_y0 | output | COORD_W+1 | Dirty box minimum row |
| dirty_x1 | output | COORD_W+1 | Dirty box maximum column (exclusive) |
| dirty_y1 | output | COORD_W+1 | Dirty box maximum row (exclusive) |

## Verification
The hardest cases to reach from the ports are the ones where arming, refusal and completion fall in the same cycle or overlap. Examples are a one-word window that is armed lazily and completes on the word that armed it, and a refused setup that arrives halfway through a pending transfer. The stimulus reaches them on purpose. It changes the window registers without a strobe, then sends words. It also issues an invalid setup between the words of a two-word transfer and checks that the remaining word still completes it. The refresh cases change `panel_h` and `panel_w` between strobes, so a reset box can be told apart from an untouched one.

// File: rtl/pws_pkg.sv
package pws_pkg;

    localparam logic [3:0] FMT_RASTER16 = 4'd1;

    // Bytes per pixel for a format code; zero marks an unsupported code.
    function automatic logic [2:0] fmt_bytes(input logic [3:0] code);
        case (code)
            4'd1:        fmt_bytes = 3'd2;
            4'd2, 4'd3:  fmt_bytes = 3'd3;
            4'd6, 4'd7:  fmt_bytes = 3'd4;
            default:     fmt_bytes = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/pws_setup.sv
module pws_setup #(
    parameter int COORD_W = 10,
    parameter int CNT_W   = 2 * COORD_W + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] x0,
    input  logic [COORD_W-1:0] y0,
    input  logic [COORD_W-1:0] x1,
    input  logic [COORD_W-1:0] y1,
    input  logic [3:0]         fmt,
    input  logic [2:0]         src,
    output logic               ok,
    output logic [CNT_W-1:0]   words,
    output logic [COORD_W:0]   width,
    output logic [COORD_W:0]   height
);
    import pws_pkg::*;

    localparam int PROD_W = CNT_W + 1;

    logic [2:0]        bpp;
    logic [PROD_W-1:0] prod;

    always_comb begin
        bpp    = fmt_bytes(fmt);
        width  = {1'b0, x1} - {1'b0, x0} + 1'b1;
        height = {1'b0, y1} - {1'b0, y0} + 1'b1;
        prod   = PROD_W'(bpp) * PROD_W'(width) * PROD_W'(height);
        words  = prod[PROD_W-1:1];
        ok     = (src <= 3'd3) && (bpp != 3'd0) && (x1 >= x0) && (y1 >= y0);
    end

    AST_OK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (words != '0)); // R2

endmodule

// File: rtl/pws_addr_gen.sv
module pws_addr_gen #(
    parameter int COORD_W = 10,
    parameter int ADDR_W  = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [ADDR_W-1:0]  base,
    input  logic [COORD_W-1:0] pitch,
    input  logic [COORD_W:0]   width,
    input  logic               raster,
    input  logic               step,
    output logic [ADDR_W-1:0]  addr_now
);
    typedef struct packed {
        logic [ADDR_W-1:0]  cur;
        logic [ADDR_W-1:0]  row;
        logic [COORD_W:0]   col;
        logic [COORD_W:0]   wid;
        logic [COORD_W-1:0] pitch;
        logic               raster;
    } ag_t;

    ag_t ag_q, ag_d, eff;

    always_comb begin
        eff = ag_q;
        if (load) begin
            eff.cur    = base;
            eff.row    = base;
            eff.col    = '0;
            eff.wid    = width;
            eff.pitch  = pitch;
            eff.raster = raster;
        end
        addr_now = eff.cur;
        ag_d     = eff;
        if (step) begin
            if (eff.raster && (eff.col == eff.wid - 1'b1)) begin
                ag_d.row = eff.row + ADDR_W'(eff.pitch);
                ag_d.cur = eff.row + ADDR_W'(eff.pitch);
                ag_d.col = '0;
            end else begin
                ag_d.cur = eff.cur + 1'b1;
                ag_d.col = eff.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ag_q <= '{cur: '0, row: '0, col: '0, wid: {{COORD_W{1'b0}}, 1'b1},
                      pitch: '0, raster: 1'b0};
        end else begin
            ag_q <= ag_d;
        end
    end

    AST_COL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ag_q.raster |-> (ag_q.col < ag_q.wid)); // R6

endmodule

// File: rtl/pws_dirty_box.sv
module pws_dirty_box #(
    parameter int COORD_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [COORD_W:0]   cx0,
    input  logic [COORD_W:0]   cy0,
    input  logic [COORD_W:0]   cx1,
    input  logic [COORD_W:0]   cy1,
    input  logic               refresh,
    input  logic [COORD_W-1:0] panel_w,
    input  logic [COORD_W-1:0] panel_h,
    output logic [COORD_W:0]   bx0,
    output logic [COORD_W:0]   by0,
    output logic [COORD_W:0]   bx1,
    output logic [COORD_W:0]   by1
);
    typedef struct packed {
        logic [COORD_W:0] x0;
        logic [COORD_W:0] y0;
        logic [COORD_W:0] x1;
        logic [COORD_W:0] y1;
    } box_t;

    box_t box_q, box_d;
    logic nonempty;

    always_comb begin
        nonempty = box_q.x1 > box_q.x0;
        box_d    = box_q;
        if (refresh && nonempty) begin
            box_d.x0 = {1'b0, panel_w};
            box_d.y0 = {1'b0, panel_h};
            box_d.x1 = '0;
            box_d.y1 = '0;
        end
        if (commit) begin
            if (cx0 < box_d.x0) box_d.x0 = cx0;
            if (cy0 < box_d.y0) box_d.y0 = cy0;
            if (cx1 > box_d.x1) box_d.x1 = cx1;
            if (cy1 > box_d.y1) box_d.y1 = cy1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            box_q <= '{x0: '1, y0: '1, x1: '0, y1: '0};
        end else begin
            box_q <= box_d;
        end
    end

    assign bx0 = box_q.x0;
    assign by0 = box_q.y0;
    assign bx1 = box_q.x1;
    assign by1 = box_q.y1;

    AST_REFRESH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh && nonempty && !commit) |=> (bx1 == '0 && by1 == '0)); // R9
    AST_COMMIT_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (bx1 >= $past(cx1) && by1 >= $past(cy1)
                    && bx0 <= $past(cx0) && by0 <= $past(cy0))); // R8

endmodule

// File: rtl/pix_window_seq.sv
module pix_window_seq #(
    parameter int COORD_W = 10,
    parameter int ADDR_W  = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] win_x0,
    input  logic [COORD_W-1:0] win_y0,
    input  logic [COORD_W-1:0] win_x1,
    input  logic [COORD_W-1:0] win_y1,
    input  logic [3:0]         fmt_code,
    input  logic [2:0]         src_sel,
    input  logic [1:0]         effect_rot,
    input  logic               setup_stb,
    input  logic               pix_valid,
    input  logic [15:0]        pix_data,
    input  logic [COORD_W-1:0] panel_w,
    input  logic [COORD_W-1:0] panel_h,
    input  logic               refresh_stb,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [15:0]        mem_data,
    output logic               done,
    output logic               busy,
    output logic [1:0]         rot_mode,
    output logic [COORD_W:0]   dirty_x0,
    output logic [COORD_W:0]   dirty_y0,
    output logic [COORD_W:0]   dirty_x1,
    output logic [COORD_W:0]   dirty_y1
);
    import pws_pkg::*;

    localparam int CNT_W = 2 * COORD_W + 4;

    typedef struct packed {
        logic [CNT_W-1:0]  rem;
        logic              done;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       data;
        logic [1:0]        rot;
        logic [COORD_W:0]  wx0;
        logic [COORD_W:0]  wy0;
        logic [COORD_W:0]  wx1;
        logic [COORD_W:0]  wy1;
    } seq_t;

    seq_t seq_q, seq_d;

    logic               set_ok;
    logic [CNT_W-1:0]   set_words;
    logic [COORD_W:0]   set_width;
    logic [COORD_W:0]   set_height;
    logic [ADDR_W-1:0]  base_addr;
    logic [ADDR_W-1:0]  addr_now;
    logic               lazy, load, word_ok, commit;
    logic [CNT_W-1:0]   rem_base;
    logic [COORD_W:0]   cx0, cy0, cx1, cy1;

    pws_setup #(.COORD_W(COORD_W), .CNT_W(CNT_W)) setup_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .x0     (win_x0),
        .y0     (win_y0),
        .x1     (win_x1),
        .y1     (win_y1),
        .fmt    (fmt_code),
        .src    (src_sel),
        .ok     (set_ok),
        .words  (set_words),
        .width  (set_width),
        .height (set_height)
    );

    assign base_addr = ADDR_W'(win_y0) * ADDR_W'(panel_w) + ADDR_W'(win_x0);

    pws_addr_gen #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) addr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .base     (base_addr),
        .pitch    (panel_w),
        .width    (set_width),
        .raster   (fmt_code == FMT_RASTER16),
        .step     (word_ok),
        .addr_now (addr_now)
    );

    always_comb begin
        seq_d    = seq_q;
        lazy     = pix_valid && !setup_stb && (seq_q.rem == '0);
        load     = (setup_stb || lazy) && set_ok;
        word_ok  = pix_valid && !setup_stb && ((seq_q.rem != '0) || load);
        rem_base = lazy ? set_words : seq_q.rem;
        commit   = word_ok && (rem_base == CNT_W'(1));

        if (setup_stb && set_ok) begin
            seq_d.rem = set_words;
        end else if (word_ok) begin
            seq_d.rem = rem_base - 1'b1;
        end

        if (load) begin
            seq_d.rot = effect_rot;
            seq_d.wx0 = {1'b0, win_x0};
            seq_d.wy0 = {1'b0, win_y0};
            seq_d.wx1 = {1'b0, win_x0} + set_width;
            seq_d.wy1 = {1'b0, win_y0} + set_height;
        end

        seq_d.we   = word_ok;
        seq_d.done = commit;
        if (word_ok) begin
            seq_d.addr = addr_now;
            seq_d.data = pix_data;
        end

        cx0 = load ? seq_d.wx0 : seq_q.wx0;
        cy0 = load ? seq_d.wy0 : seq_q.wy0;
        cx1 = load ? seq_d.wx1 : seq_q.wx1;
        cy1 = load ? seq_d.wy1 : seq_q.wy1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    pws_dirty_box #(.COORD_W(COORD_W)) box_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .cx0     (cx0),
        .cy0     (cy0),
        .cx1     (cx1),
        .cy1     (cy1),
        .refresh (refresh_stb),
        .panel_w (panel_w),
        .panel_h (panel_h),
        .bx0     (dirty_x0),
        .by0     (dirty_y0),
        .bx1     (dirty_x1),
        .by1     (dirty_y1)
    );

    assign mem_we   = seq_q.we;
    assign mem_addr = seq_q.addr;
    assign mem_data = seq_q.data;
    assign done     = seq_q.done;
    assign busy     = seq_q.rem != '0;
    assign rot_mode = seq_q.rot;

    AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> mem_we); // R7
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R7
    AST_COLLIDE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_stb && pix_valid) |=> !mem_we); // R11

endmodule

// File: tb/pix_window_seq_tb_top.sv
module pix_window_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 10;
    localparam int AW = 20;
    localparam int PW = 32;
    localparam int PH = 16;

    typedef struct packed {
        logic [9:0] x0, y0, x1, y1;
        logic [3:0] fmt;
        logic [2:0] src;
        logic [7:0] words;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{10'd2, 10'd1, 10'd4, 10'd2, 4'd1, 3'd0, 8'd6},
        '{10'd0, 10'd0, 10'd1, 10'd0, 4'd2, 3'd1, 8'd3},
        '{10'd5, 10'd5, 10'd5, 10'd5, 4'd3, 3'd2, 8'd1},
        '{10'd0, 10'd0, 10'd2, 10'd1, 4'd6, 3'd3, 8'd12},
        '{10'd1, 10'd1, 10'd1, 10'd2, 4'd7, 3'd0, 8'd4},
        '{10'd0, 10'd0, 10'd1, 10'd1, 4'd0, 3'd0, 8'd0},
        '{10'd0, 10'd0, 10'd1, 10'd1, 4'd4, 3'd0, 8'd0},
        '{10'd0, 10'd0, 10'd1, 10'd1, 4'd1, 3'd4, 8'd0},
        '{10'd3, 10'd0, 10'd2, 10'd1, 4'd1, 3'd0, 8'd0},
        '{10'd0, 10'd4, 10'd1, 10'd3, 4'd1, 3'd0, 8'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] win_x0 = '0, win_y0 = '0, win_x1 = '0, win_y1 = '0;
    logic [3:0] fmt_code = '0;
    logic [2:0] src_sel = '0;
    logic [1:0] effect_rot = '0;
    logic setup_stb = 1'b0, pix_valid = 1'b0, refresh_stb = 1'b0;
    logic [15:0] pix_data = '0;
    logic [CW-1:0] panel_w = CW'(PW), panel_h = CW'(PH);
    logic mem_we, done, busy;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_data;
    logic [1:0] rot_mode;
    logic [CW:0] dirty_x0, dirty_y0, dirty_x1, dirty_y1;

    int checks = 0;
    int failures = 0;
    int ex0, ey0, ex1, ey1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_window_seq #(.COORD_W(CW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .win_x0(win_x0), .win_y0(win_y0), .win_x1(win_x1), .win_y1(win_y1),
        .fmt_code(fmt_code), .src_sel(src_sel), .effect_rot(effect_rot),
        .setup_stb(setup_stb), .pix_valid(pix_valid), .pix_data(pix_data),
        .panel_w(panel_w), .panel_h(panel_h), .refresh_stb(refresh_stb),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .done(done), .busy(busy), .rot_mode(rot_mode),
        .dirty_x0(dirty_x0), .dirty_y0(dirty_y0),
        .dirty_x1(dirty_x1), .dirty_y1(dirty_y1)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_win(input int x0, input int y0, input int x1, input int y1,
                           input int fmt, input int src);
        win_x0 = CW'(x0); win_y0 = CW'(y0); win_x1 = CW'(x1); win_y1 = CW'(y1);
        fmt_code = 4'(fmt); src_sel = 3'(src);
    endtask

    task automatic pulse_setup();
        setup_stb = 1'b1;
        @(negedge clk);
        setup_stb = 1'b0;
    endtask

    task automatic send_word(input int d, output bit we, output int ad,
                             output int dat, output bit dn);
        pix_valid = 1'b1;
        pix_data = 16'(d);
        @(negedge clk);
        pix_valid = 1'b0;
        we = mem_we; ad = int'(mem_addr); dat = int'(mem_data); dn = done;
    endtask

    task automatic merge(input int x0, input int y0, input int x1, input int y1);
        if (x0 < ex0) ex0 = x0;
        if (y0 < ey0) ey0 = y0;
        if (x1 + 1 > ex1) ex1 = x1 + 1;
        if (y1 + 1 > ey1) ey1 = y1 + 1;
    endtask

    task automatic check_box(input string req);
        check(int'(dirty_x0) == ex0, req, int'(dirty_x0), ex0);
        check(int'(dirty_y0) == ey0, req, int'(dirty_y0), ey0);
        check(int'(dirty_x1) == ex1, req, int'(dirty_x1), ex1);
        check(int'(dirty_y1) == ey1, req, int'(dirty_y1), ey1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit we, dn;
        int ad, dat, w, expa;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(mem_we == 1'b0, "R1 mem_we", int'(mem_we), 0);
        ex0 = 2047; ey0 = 2047; ex1 = 0; ey1 = 0;
        check_box("R1 dirty box");

        // table walk: R2 R3 R4 R6 R7 R8 R10 R12
        for (int v = 0; v < NV; v++) begin
            set_win(int'(VECS[v].x0), int'(VECS[v].y0), int'(VECS[v].x1),
                    int'(VECS[v].y1), int'(VECS[v].fmt), int'(VECS[v].src));
            effect_rot = 2'(v);
            pulse_setup();
            effect_rot = 2'(v + 1);
            if (VECS[v].words == 0) begin
                check(busy == 1'b0, "R3 refused setup", int'(busy), 0);
                send_word(16'hdead, we, ad, dat, dn);
                check(we == 1'b0, "R3 refused word", int'(we), 0);
            end else begin
                check(busy == 1'b1, "R4 busy after setup", int'(busy), 1);
                check(rot_mode == 2'(v), "R10 rotation", int'(rot_mode), v % 4);
                w = int'(VECS[v].x1) - int'(VECS[v].x0) + 1;
                for (int i = 0; i < int'(VECS[v].words); i++) begin
                    send_word(256 + i, we, ad, dat, dn);
                    if (VECS[v].fmt == 4'd1)
                        expa = (int'(VECS[v].y0) + i / w) * PW + int'(VECS[v].x0) + i % w;
                    else
                        expa = int'(VECS[v].y0) * PW + int'(VECS[v].x0) + i;
                    check(we == 1'b1, "R12 write", int'(we), 1);
                    check(dat == 256 + i, "R12 data", dat, 256 + i);
                    check(ad == expa, "R6 address", ad, expa);
                    check(dn == (i == int'(VECS[v].words) - 1), "R2 R7 done timing",
                          int'(dn), int'(i == int'(VECS[v].words) - 1));
                end
                check(busy == 1'b0, "R7 busy falls", int'(busy), 0);
                merge(int'(VECS[v].x0), int'(VECS[v].y0), int'(VECS[v].x1), int'(VECS[v].y1));
                check_box("R8 dirty merge");
            end
        end

        // R9 refresh of a non-empty box, then of an empty one
        refresh_stb = 1'b1;
        @(negedge clk);
        refresh_stb = 1'b0;
        ex0 = PW; ey0 = PH; ex1 = 0; ey1 = 0;
        check_box("R9 refresh resets");
        panel_w = CW'(20); panel_h = CW'(9);
        refresh_stb = 1'b1;
        @(negedge clk);
        refresh_stb = 1'b0;
        check_box("R9 empty refresh ignored");
        panel_w = CW'(PW); panel_h = CW'(PH);

        // R5 lazy arming
        set_win(3, 2, 4, 2, 1, 0);
        send_word(16'h0a0a, we, ad, dat, dn);
        check(we == 1'b1, "R5 lazy first word", int'(we), 1);
        check(ad == 2 * PW + 3, "R5 lazy address", ad, 2 * PW + 3);
        check(busy == 1'b1, "R5 lazy busy", int'(busy), 1);
        send_word(16'h0b0b, we, ad, dat, dn);
        check(dn == 1'b1, "R5 lazy done", int'(dn), 1);
        check(ad == 2 * PW + 4, "R6 lazy second address", ad, 2 * PW + 4);
        merge(3, 2, 4, 2);
        check_box("R8 lazy merge");

        // R3 lazy refused word
        set_win(0, 0, 1, 1, 0, 0);
        send_word(16'h1111, we, ad, dat, dn);
        check(we == 1'b0, "R3 lazy refused no write", int'(we), 0);
        check(busy == 1'b0, "R3 lazy refused idle", int'(busy), 0);

        // R3 refused setup mid-transfer keeps pending count
        set_win(0, 0, 1, 0, 1, 0);
        pulse_setup();
        send_word(16'h2222, we, ad, dat, dn);
        set_win(0, 0, 1, 0, 5, 0);
        pulse_setup();
        check(busy == 1'b1, "R3 refused keeps busy", int'(busy), 1);
        send_word(16'h3333, we, ad, dat, dn);
        check(dn == 1'b1, "R3 pending count kept", int'(dn), 1);

        // R11 word with setup strobe is dropped
        set_win(0, 0, 0, 0, 1, 0);
        setup_stb = 1'b1;
        pix_valid = 1'b1;
        @(negedge clk);
        setup_stb = 1'b0;
        pix_valid = 1'b0;
        check(mem_we == 1'b0, "R11 collided word dropped", int'(mem_we), 0);
        check(busy == 1'b1, "R11 setup still taken", int'(busy), 1);
        send_word(16'h4444, we, ad, dat, dn);
        check(dn == 1'b1, "R11 following word completes", int'(dn), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule